// File: doc/BRIEF.md
# LED Sink Grouping and PWM Gating Logic

This block sits between the register file of a six-sink LED driver and its analog current sinks. From a general control byte and a grouping byte it works out, for every sink, whether the sink is switched on and which 6-bit brightness code sets its current. Sinks can join a shared group that has one enable and one brightness level. Two pairs of independent sinks can also be tied so that both sinks of a pair share a brightness code. The block also passes the 2-bit full-scale current selection to a separate output.

An external PWM pin can be turned into a dimming input for the shared group. It first crosses into the clock domain through a synchronizer. While PWM dimming is selected, the synchronized level blanks the group's sinks whenever it is low. Sinks outside the group never see it. All outputs are registered, so a register change appears one clock later.

Top module: `led_group_gate`

## Requirements
- R1: While rst_n is low, every drive enable, every brightness code and the full-scale code are 0.
- R2: Sinks 1 and 2 always belong to the shared group. Sink k (3 to 6) joins it when grp_i bit k-1 is 1. A member drives when ctl_i bit 0 is 1, whatever its own enable bit, and takes the shared code from lvl_i slot 0.
- R3: A sink k (3 to 6) outside the group drives when ctl_i bit k-2 is 1, and takes the code in lvl_i slot k-2 (slot j holds bits 6j+5..6j).
- R4: When grp_i bit 6 is 1, sink 4 takes the sink 3 code (slot 1). When grp_i bit 7 is 1, sink 6 takes the sink 5 code (slot 3). A tie changes no enable.
- R5: A tie is void when either sink of its pair is in the shared group. Each sink then follows R2 or R3.
- R6: When ctl_i bit 7 is 1 and the synchronized PWM level is 0, every group member is off.
- R7: A sink outside the group has the same enable for either PWM level and either value of ctl_i bit 7.
- R8: A change on pwm_i reaches drv_en_o on the third rising clock edge after it, and not before. A change on ctl_i, grp_i or lvl_i reaches the outputs on the next rising edge.
- R9: fs_code_o equals {ctl_i[6], ctl_i[5]}. The codes mean 00 = 20 mA, 01 = 30 mA, 10 = 15 mA and 11 = 8 mA full scale.
- R10: The brightness code for sink k sits on drv_code_o bits 6(k-1)+5..6(k-1). It is copied unchanged from its source slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 8 | General control: enables [4:0], full scale [6:5], PWM mode [7] |
| grp_i | input | 8 | Grouping: join bits [5:2], pair ties [7:6] |
| lvl_i | input | 30 | Five 6-bit brightness codes, slot 0 shared, slots 1-4 sinks 3-6 |
| pwm_i | input | 1 | Asynchronous PWM dimming level |
| drv_en_o | output | 6 | Per-sink drive enable, bit k-1 for sink k |
| drv_code_o | output | 36 | Per-sink brightness code |
| fs_code_o | output | 2 | Full-scale current selection |

## Verification
The bench builds the block with its default parameters: a 6-bit code width and a 2-stage synchronizer. At that size the full space of the grouping byte can be swept. It is crossed with 64 control patterns that cover every enable combination, both states of PWM mode and all four full-scale codes, for both PWM levels. This reaches every combination of join and tie override, including ties voided from either side of a pair. The brightness slots change on every vector, so a code taken from the wrong source shows up. A separate step measures the PWM latency edge by edge.

// File: rtl/ledgrp_pkg.sv
package ledgrp_pkg;

    // Sink and source counts fixed by the register layout
    localparam int SINKS    = 6;
    localparam int SOURCES  = 5;
    localparam int FIXED_A  = 2;

    // Control byte field positions
    localparam int CTL_ENA   = 0;
    localparam int CTL_FS_LO = 5;
    localparam int CTL_FS_HI = 6;
    localparam int CTL_PWM   = 7;

    // Grouping byte: first tie bit (pair 3/4), next is pair 5/6
    localparam int GRP_TIE0  = 6;

    localparam int EN_BITS   = 5;

endpackage

// File: rtl/ledgrp_sync.sv
module ledgrp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ledgrp_route.sv
module ledgrp_route
    import ledgrp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [EN_BITS-1:0]        en_bits_i,
    input  logic [7:0]                grp_i,
    input  logic [SOURCES*CODE_W-1:0] lvl_i,
    output logic [SINKS-1:0]          member_o,
    output logic [SINKS-1:0]          en_o,
    output logic [SINKS*CODE_W-1:0]   code_o
);

    for (genvar k = 0; k < SINKS; k++) begin : g_sink
        if (k < FIXED_A) begin : g_fixed
            // Always in the shared group
            assign member_o[k] = 1'b1;
            assign en_o[k]     = en_bits_i[CTL_ENA];
            assign code_o[k*CODE_W +: CODE_W] = lvl_i[0 +: CODE_W];
        end else begin : g_free
            localparam int OWN_SLOT = k - 1;
            logic tied;
            logic joined;

            if (k % 2 == 1) begin : g_follower
                // Second sink of a pair; tie void if either sink joined
                assign tied = grp_i[GRP_TIE0 + (k - 3) / 2]
                            & ~grp_i[k - 1] & ~grp_i[k];
            end else begin : g_leader
                assign tied = 1'b0;
            end

            assign joined      = grp_i[k];
            assign member_o[k] = joined;

            always_comb begin
                if (joined) begin
                    en_o[k] = en_bits_i[CTL_ENA];
                    code_o[k*CODE_W +: CODE_W] = lvl_i[0 +: CODE_W];
                end else begin
                    en_o[k] = en_bits_i[k - 1];
                    if (tied) code_o[k*CODE_W +: CODE_W] = lvl_i[(OWN_SLOT-1)*CODE_W +: CODE_W];
                    else      code_o[k*CODE_W +: CODE_W] = lvl_i[OWN_SLOT*CODE_W +: CODE_W];
                end
            end
        end
    end

endmodule

// File: rtl/led_group_gate.sv
module led_group_gate
    import ledgrp_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [7:0]                  ctl_i,
    input  logic [7:0]                  grp_i,
    input  logic [SOURCES*CODE_W-1:0]   lvl_i,
    input  logic                        pwm_i,
    output logic [SINKS-1:0]            drv_en_o,
    output logic [SINKS*CODE_W-1:0]     drv_code_o,
    output logic [1:0]                  fs_code_o
);

    typedef struct packed {
        logic [SINKS-1:0]        en;
        logic [SINKS*CODE_W-1:0] code;
        logic [1:0]              fs;
    } drive_t;

    drive_t st_d, st_q;

    logic                    pwm_s;
    logic [SINKS-1:0]        member;
    logic [SINKS-1:0]        en_raw;
    logic [SINKS*CODE_W-1:0] code_raw;
    logic                    blank;

    ledgrp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwm_i),
        .sync_o  (pwm_s)
    );

    ledgrp_route #(.CODE_W(CODE_W)) i_route (
        .en_bits_i (ctl_i[EN_BITS-1:0]),
        .grp_i     (grp_i),
        .lvl_i     (lvl_i),
        .member_o  (member),
        .en_o      (en_raw),
        .code_o    (code_raw)
    );

    always_comb begin
        blank   = ctl_i[CTL_PWM] & ~pwm_s;
        st_d.en   = en_raw & ~(member & {SINKS{blank}});
        st_d.code = code_raw;
        st_d.fs   = {ctl_i[CTL_FS_HI], ctl_i[CTL_FS_LO]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drv_en_o   = st_q.en;
    assign drv_code_o = st_q.code;
    assign fs_code_o  = st_q.fs;

    // R9: full-scale selection copied with one cycle of delay
    a_r9_fs_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fs_code_o == {$past(ctl_i[6]), $past(ctl_i[5])});

    // R2: the two fixed sinks follow the shared enable and code
    a_r2_fixed_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> drv_code_o[CODE_W +: CODE_W] == $past(lvl_i[0 +: CODE_W]));

    a_r2_fixed_en: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(ctl_i[0]) |-> !drv_en_o[0] && !drv_en_o[1]);

    // R4: tie of pair 3/4 with neither sink joined
    a_r4_tie_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(grp_i[6] && !grp_i[2] && !grp_i[3])
        |-> drv_code_o[3*CODE_W +: CODE_W] == $past(lvl_i[CODE_W +: CODE_W]));

    // R5: a joined follower ignores its tie
    a_r5_join_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(grp_i[5])
        |-> drv_code_o[5*CODE_W +: CODE_W] == $past(lvl_i[0 +: CODE_W]));

    for (genvar k = 0; k < SINKS; k++) begin : g_chk
        // R6: members are blanked while PWM mode holds the pin low
        a_r6_pwm_blanks: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(member[k] && ctl_i[7] && !pwm_s) |-> !drv_en_o[k]);

        // R7: non-members take their routed enable regardless of PWM
        a_r7_nonmember_free: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(member[k]) |-> drv_en_o[k] == $past(en_raw[k]));
    end

endmodule

// File: tb/test_led_group_gate.sv
module test_led_group_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctl = '0;
    logic [7:0]  grp = '0;
    logic [29:0] lvl = '0;
    logic        pwm = 1'b0;
    logic [5:0]  drv_en;
    logic [35:0] drv_code;
    logic [1:0]  fs_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    led_group_gate i_led_group_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl),
        .grp_i      (grp),
        .lvl_i      (lvl),
        .pwm_i      (pwm),
        .drv_en_o   (drv_en),
        .drv_code_o (drv_code),
        .fs_code_o  (fs_code)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected sink behaviour written from the requirements
    task automatic model(input logic [7:0] c, input logic [7:0] g, input logic [29:0] lv,
                         input logic p, output logic [5:0] en, output logic [35:0] code);
        for (int k = 0; k < 6; k++) begin
            logic in_grp;
            int   slot;
            logic e;
            in_grp = (k < 2) ? 1'b1 : c[k];
            if (in_grp) begin
                e = g[0];
                slot = 0;
            end else begin
                e = g[k-1];
                slot = k - 1;
                if (k == 3 && c[6] && !c[2] && !c[3]) slot = 1;
                if (k == 5 && c[7] && !c[4] && !c[5]) slot = 3;
            end
            if (in_grp && g[7] && !p) e = 1'b0;
            en[k] = e;
            code[k*6 +: 6] = lv[slot*6 +: 6];
        end
    endtask

    initial begin
        logic [5:0]  exp_en;
        logic [35:0] exp_code;

        // R1: outputs stay cleared while reset is held, even with live inputs
        ctl = 8'hFF; grp = 8'h3C; lvl = 30'h2AAA_AAAA; pwm = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 enables in reset", {30'd0, drv_en}, 36'd0);
        check("R1 codes in reset", drv_code, 36'd0);
        check("R1 full scale in reset", {34'd0, fs_code}, 36'd0);
        rst_n = 1'b1;

        // Full sweep of grouping byte against control patterns, both PWM levels
        for (int p = 0; p < 2; p++) begin
            pwm = p[0];
            repeat (4) @(negedge clk);
            for (int c = 0; c < 256; c++) begin
                for (int g = 0; g < 64; g++) begin
                    logic [7:0] gv;
                    gv = {g[5], c[7] ^ g[0], c[6] ^ g[1], g[4:0]};
                    grp = c[7:0];
                    ctl = gv;
                    for (int s = 0; s < 5; s++)
                        lvl[s*6 +: 6] = 6'((g * 7 + s * 13 + c * 3 + p * 29) & 63);
                    model(grp, ctl, lvl, pwm, exp_en, exp_code);
                    @(negedge clk);
                    check("R2 R3 R6 R7 enables", {30'd0, drv_en}, {30'd0, exp_en});
                    check("R2 R4 R5 R10 codes", drv_code, exp_code);
                    check("R9 full scale", {34'd0, fs_code}, {34'd0, gv[6], gv[5]});
                end
            end
        end

        // R8: latency of the PWM pin into the group enables
        grp = 8'h00; ctl = 8'h81; pwm = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 settled low", {30'd0, drv_en}, 36'd0);
        pwm = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 not before third edge", {30'd0, drv_en}, 36'd0);
        @(negedge clk);
        check("R8 on third edge", {30'd0, drv_en}, {30'd0, 6'b000011});
        pwm = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 still on after two edges", {30'd0, drv_en}, {30'd0, 6'b000011});
        @(negedge clk);
        check("R8 off on third edge", {30'd0, drv_en}, 36'd0);

        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 200000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule